// File: doc/BRIEF.md
# Monitor-Gated Interrupt Flag Register

This block holds the nine sticky interrupt and exit flags of a processor and decides when a context exchange must be requested. Each cycle it takes raw condition pulses and the decoded error-exit and normal-exit strobes. It passes each one through a permission mask. The mask is built from three things: the monitor-mode bits of the active context, a global interrupt enable, and a strap that selects whether the monitor-mode interrupt option is fitted. A condition that is permitted sets its flag. A condition that is masked leaves the flag clear and raises no request.

The exchange request is a single-cycle pulse. It fires when a flag goes from clear to set. It also fires when an exit strobe arrives while the context is in monitor mode, even if the exit flag itself stays masked. The exchange sequencer clears the flags through a dedicated input. The mode bits of the context are registered inside the block, so a change of mode governs the conditions of the following cycle.

Flag bit positions: 0 memory error, 1 error exit, 2 normal exit, 3 PC interrupt, 4 MCU interrupt, 5 I/O interrupt, 6 to 8 general conditions. The error-exit strobe is ORed into condition bit 1 and the normal-exit strobe into condition bit 2. Monitor mode means `mode_hi_i` = 1. Level 1 is `mode_lo_i` = 0 and level 2 is `mode_lo_i` = 1.

Top module: `monitor_flag_gate`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flags_o` is 0 and `xreq_o` is 0.
- R2: A flag stays set until `clr_flags_i` is asserted. A permitted condition sets its flag on the next clock edge.
- R3: With `mon_opt_i` = 0, memory error (bit 0) is always permitted. Every other flag is permitted only when monitor mode is off.
- R4: With `mon_opt_i` = 1 and monitor mode off, all nine flags are permitted when `int_en_i` = 1 and none is permitted when `int_en_i` = 0.
- R5: With `mon_opt_i` = 1 in monitor level 1, only bit 0 is permitted, and only when at least one bit of `par_mode_i` is 1.
- R6: With `mon_opt_i` = 1 in monitor level 2, bits 2, 3, 4 and 5 are masked and bits 0, 1, 6, 7 and 8 are permitted.
- R7: In monitor mode, under either strap value, an asserted `err_exit_i` or `norm_exit_i` raises `xreq_o` on the next cycle even when its flag is masked.
- R8: `xreq_o` is high for exactly the cycle after an edge in which at least one flag went from clear to set or R7 applied, and is low otherwise. A masked condition raises no request.
- R9: `clr_flags_i` clears all flags on the next edge. A condition permitted in the same cycle still sets its flag, because setting takes priority over clearing.
- R10: `mode_hi_i`, `mode_lo_i` and `par_mode_i` are registered. A value applied before edge k gates the conditions applied before edge k+1 and after, not those at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 9 | Raw condition pulses, one per flag |
| mode_hi_i | input | 1 | Monitor-mode bit of the active context |
| mode_lo_i | input | 1 | Monitor-level bit (0 level 1, 1 level 2) |
| par_mode_i | input | 2 | Parity-error mode bits of the active context |
| int_en_i | input | 1 | Global interrupt enable |
| mon_opt_i | input | 1 | Strap: monitor-mode interrupt option fitted |
| err_exit_i | input | 1 | Decoded error-exit instruction strobe |
| norm_exit_i | input | 1 | Decoded normal-exit instruction strobe |
| clr_flags_i | input | 1 | Clear all flags (from the exchange sequencer) |
| flags_o | output | 9 | Flag register |
| xreq_o | output | 1 | Exchange request, one-cycle pulse |

## Verification
The assertions check on every cycle that flags are sticky, that level 1 and level 2 never set a flag they mask, that a disabled interrupt enable freezes the flags, and that every new flag, and only a new flag or a forced exit, comes with a request pulse. Some behaviours can only be shown by the bench's scenarios, which compare both outputs against an independent cycle model. These are the strap-absent gating, the parity condition on memory error, the one-cycle lag of a mode change, and set-over-clear priority.

// File: rtl/monitor_flag_gate_pkg.sv
package monitor_flag_gate_pkg;
  localparam int NFLAG   = 9;
  localparam int PAR_W   = 2;
  localparam int F_MEM   = 0;
  localparam int F_EEXIT = 1;
  localparam int F_NEXIT = 2;
  localparam int F_PC    = 3;
  localparam int F_MCU   = 4;
  localparam int F_IO    = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;

  function automatic flag_vec_t level2_block();
    flag_vec_t m;
    m = '0;
    m[F_NEXIT] = 1'b1;
    m[F_PC]    = 1'b1;
    m[F_MCU]   = 1'b1;
    m[F_IO]    = 1'b1;
    return m;
  endfunction

  function automatic flag_vec_t mem_only();
    flag_vec_t m;
    m = '0;
    m[F_MEM] = 1'b1;
    return m;
  endfunction

  // Permission mask for one cycle, from option strap and registered mode.
  function automatic flag_vec_t permit_mask(input logic opt, input logic mon,
                                            input logic lvl2, input logic ie,
                                            input logic par_any);
    flag_vec_t m;
    if (!opt) begin
      m = mon ? mem_only() : '1;
    end else if (!mon) begin
      m = ie ? '1 : '0;
    end else if (!lvl2) begin
      m = par_any ? mem_only() : '0;
    end else begin
      m = ~level2_block();
    end
    return m;
  endfunction
endpackage

// File: rtl/fgm_mode_reg.sv
module fgm_mode_reg
  import monitor_flag_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_i,
  input  logic             lo_i,
  input  logic [PAR_W-1:0] par_i,
  output logic             hi_q,
  output logic             lo_q,
  output logic [PAR_W-1:0] par_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      par_q <= '0;
    end else begin
      hi_q  <= hi_i;
      lo_q  <= lo_i;
      par_q <= par_i;
    end
  end
endmodule

// File: rtl/fgm_permit.sv
module fgm_permit
  import monitor_flag_gate_pkg::*;
(
  input  logic             opt_i,
  input  logic             mon_i,
  input  logic             lvl2_i,
  input  logic             ie_i,
  input  logic [PAR_W-1:0] par_i,
  input  logic             eexit_i,
  input  logic             nexit_i,
  output flag_vec_t        permit_o,
  output logic             forced_o
);
  assign permit_o = permit_mask(opt_i, mon_i, lvl2_i, ie_i, |par_i);
  assign forced_o = mon_i & (eexit_i | nexit_i);
endmodule

// File: rtl/fgm_flag_store.sv
module fgm_flag_store
  import monitor_flag_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  logic      clr_i,
  input  logic      forced_i,
  output flag_vec_t flags_q,
  output flag_vec_t fresh_o,
  output logic      xreq_q
);
  flag_vec_t flags_d;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    assign fresh_o[i] = set_i[i] & ~flags_q[i];
    assign flags_d[i] = set_i[i] | (flags_q[i] & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      xreq_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      xreq_q  <= (|fresh_o) | forced_i;
    end
  end
endmodule

// File: rtl/monitor_flag_gate.sv
module monitor_flag_gate
  import monitor_flag_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] cond_i,
  input  logic       mode_hi_i,
  input  logic       mode_lo_i,
  input  logic [1:0] par_mode_i,
  input  logic       int_en_i,
  input  logic       mon_opt_i,
  input  logic       err_exit_i,
  input  logic       norm_exit_i,
  input  logic       clr_flags_i,
  output logic [8:0] flags_o,
  output logic       xreq_o
);
  logic             mon_q;
  logic             lvl2_q;
  logic [PAR_W-1:0] par_q;
  flag_vec_t        permit_w;
  flag_vec_t        cond_w;
  flag_vec_t        set_w;
  flag_vec_t        fresh_w;
  logic             forced_w;
  logic             mon1_w;
  logic             mon2_w;

  fgm_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .hi_i  (mode_hi_i),
    .lo_i  (mode_lo_i),
    .par_i (par_mode_i),
    .hi_q  (mon_q),
    .lo_q  (lvl2_q),
    .par_q (par_q)
  );

  fgm_permit u_permit (
    .opt_i    (mon_opt_i),
    .mon_i    (mon_q),
    .lvl2_i   (lvl2_q),
    .ie_i     (int_en_i),
    .par_i    (par_q),
    .eexit_i  (err_exit_i),
    .nexit_i  (norm_exit_i),
    .permit_o (permit_w),
    .forced_o (forced_w)
  );

  always_comb begin
    cond_w          = cond_i;
    cond_w[F_EEXIT] = cond_i[F_EEXIT] | err_exit_i;
    cond_w[F_NEXIT] = cond_i[F_NEXIT] | norm_exit_i;
  end

  assign set_w  = cond_w & permit_w;
  assign mon1_w = mon_q & ~lvl2_q;
  assign mon2_w = mon_q & lvl2_q;

  fgm_flag_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_w),
    .clr_i    (clr_flags_i),
    .forced_i (forced_w),
    .flags_q  (flags_o),
    .fresh_o  (fresh_w),
    .xreq_q   (xreq_o)
  );
endmodule

// File: rtl/monitor_flag_gate_chk.sv
module monitor_flag_gate_chk
  import monitor_flag_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] flags,
  input logic       xreq,
  input logic       clr,
  input logic       opt,
  input logic       ie,
  input logic       mon,
  input logic       mon1,
  input logic       mon2,
  input logic       forced
);
  localparam logic [8:0] BLK2 = level2_block();

  // R2: flags are sticky without a clear
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  // R4: option fitted, monitor off, interrupts disabled: nothing changes
  p_ie_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opt && !mon && !ie && !clr) |=> (flags == $past(flags)));

  // R5: level 1 never touches bits above memory error
  p_level1_mem_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opt && mon1 && !clr) |=> (flags[8:1] == $past(flags[8:1])));

  // R6: level 2 never newly sets a blocked flag
  p_level2_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opt && mon2) |=> (((flags & ~$past(flags)) & BLK2) == '0));

  // R7: exit strobe in monitor mode forces a request
  p_forced_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> xreq);

  // R8: a newly set flag comes with a request
  p_new_flag_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) != '0) |-> xreq);

  // R8: a request has a cause
  p_req_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xreq |-> (((flags & ~$past(flags)) != '0) || $past(forced)));
endmodule

bind monitor_flag_gate monitor_flag_gate_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .flags  (flags_o),
  .xreq   (xreq_o),
  .clr    (clr_flags_i),
  .opt    (mon_opt_i),
  .ie     (int_en_i),
  .mon    (mon_q),
  .mon1   (mon1_w),
  .mon2   (mon2_w),
  .forced (forced_w)
);

// File: tb/monitor_flag_gate_test.sv
module monitor_flag_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cond = '0;
  logic       mhi = 1'b0, mlo = 1'b0;
  logic [1:0] par = '0;
  logic       ie = 1'b0, opt = 1'b0, eex = 1'b0, nex = 1'b0, clr = 1'b0;
  logic [8:0] flags;
  logic       xreq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  logic [8:0] m_flags = '0;
  logic       m_xreq = 1'b0;
  logic       m_hi = 1'b0, m_lo = 1'b0;
  logic [1:0] m_par = '0;
  bit         m_forced = 0;

  always #5 clk = ~clk;

  monitor_flag_gate uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .mode_hi_i(mhi), .mode_lo_i(mlo),
    .par_mode_i(par), .int_en_i(ie), .mon_opt_i(opt), .err_exit_i(eex),
    .norm_exit_i(nex), .clr_flags_i(clr), .flags_o(flags), .xreq_o(xreq)
  );

  // Per-flag permission, written per bit from the requirements
  function automatic bit allowed(int b, bit o, bit hi, bit lo, bit en, logic [1:0] p);
    if (!o) return (b == 0) ? 1'b1 : !hi;                  // R3
    if (!hi) return en;                                   // R4
    if (!lo) return (b == 0) && (p != 2'b00);             // R5
    return !(b == 2 || b == 3 || b == 4 || b == 5);       // R6
  endfunction

  function automatic string tag_now();
    if (!opt) return "R3";
    if (!m_hi) return "R4";
    if (!m_lo) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [8:0] f_e, logic x_e);
    compared++;
    if (flags !== f_e) begin
      mismatched++;
      $display("FAIL %s flags actual=%h expected=%h", req, flags, f_e);
    end
    compared++;
    if (xreq !== x_e) begin
      mismatched++;
      $display("FAIL %s xreq actual=%b expected=%b", req, xreq, x_e);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step(string req);
    logic [8:0] ce, ok, nw;
    @(posedge clk);
    ce = cond;
    ce[1] = ce[1] | eex;
    ce[2] = ce[2] | nex;
    ok = '0;
    for (int b = 0; b < 9; b++)
      ok[b] = ce[b] & allowed(b, opt, m_hi, m_lo, ie, m_par);
    nw = ok & ~m_flags;
    m_forced = m_hi && (eex || nex);
    m_xreq = (nw != 0) || m_forced;
    m_flags = clr ? ok : (m_flags | ok);
    m_hi = mhi; m_lo = mlo; m_par = par;
    @(negedge clk);
    check(m_forced ? "R7" : req, m_flags, m_xreq);
    cond = '0; eex = 0; nex = 0; clr = 0;
  endtask

  task automatic idle();
    cond = '0; eex = 0; nex = 0; clr = 0;
  endtask

  initial begin
    #(10 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1", 9'h000, 1'b0);
    rst_n = 1;
    idle();
    step("R1");

    // R3: strap absent, monitor off, all conditions set
    opt = 0; mhi = 0; mlo = 0; ie = 0;
    step("R10");
    cond = 9'h1FF; step("R3");
    step("R2");           // sticky, no second pulse (R8)
    cond = 9'h1FF; step("R8");  // already set: no pulse
    clr = 1; cond = 9'h040; step("R9");  // set wins over clear
    clr = 1; step("R9");

    // R10: mode change takes effect one cycle later
    mhi = 1; cond = 9'h008; step("R10"); // old mode off: PC int sets
    cond = 9'h010; step("R3");           // monitor now: masked
    cond = 9'h001; step("R3");           // memory error still permitted
    eex = 1; step("R7");                 // forced request, flag masked
    clr = 1; step("R9");

    // R4: option fitted, monitor off, enable off then on
    opt = 1; mhi = 0; step("R10");
    ie = 0; cond = 9'h1FF; step("R4");
    ie = 1; cond = 9'h120; step("R4");
    clr = 1; step("R9");

    // R5: level 1, parity bits
    mhi = 1; mlo = 0; par = 2'b00; step("R10");
    cond = 9'h1FF; step("R5");
    par = 2'b10; step("R10");
    cond = 9'h1FF; step("R5");
    nex = 1; step("R7");
    clr = 1; step("R9");

    // R6: level 2
    mlo = 1; step("R10");
    cond = 9'h1FF; step("R6");
    nex = 1; step("R7");
    clr = 1; step("R9");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cond = 9'($urandom & $urandom & $urandom);
      mhi = $urandom_range(0, 1);
      mlo = $urandom_range(0, 1);
      par = 2'($urandom);
      ie  = ($urandom_range(0, 3) != 0);
      if ((n % 500) == 0) opt = ~opt;
      eex = ($urandom_range(0, 15) == 0);
      nex = ($urandom_range(0, 15) == 0);
      clr = ($urandom_range(0, 7) == 0);
      step(tag_now());
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule